// File: doc/BRIEF.md
# Posted Column Command Latency Scheduler

This block sits behind the command decoder of a DDR2-style memory device. It lets a read or write column command be accepted early, before the row-to-column delay has run out. The command is held inside the block for a programmable additive latency and then released as an internal column strobe. From that same command the block derives the cycle on which read data begins and the cycle on which write data is due. Read latency is the additive latency plus the CAS latency. Write latency is one cycle shorter than read latency.

The additive latency is loaded by an extended mode register write, which carries a 3-bit field in the address. A code outside the legal range leaves the current setting in place. The CAS latency comes in as a plain input. Any number of posted commands may be in flight at the same time, and they leave the block in the order they came in. The block also watches the gap between each activate and the column commands that follow it. When a column command becomes internally valid before the row-to-column delay has been met, the block raises a timing-violation flag in the same cycle as that command's strobe.

Top module: `pcas_sched`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, all five outputs are low, and the additive latency is 0.
- R2: The command input uses these codes: 0 = idle, 1 = activate, 2 = read, 3 = write, 4 = extended mode write; codes 5 to 7 act as idle. An extended mode write with `addr_i[5:3]` in the range 0 to 4 sets the additive latency (AL) to that value.
- R3: An extended mode write with `addr_i[5:3]` equal to 5, 6 or 7 leaves AL unchanged.
- R4: A read (or write) sampled at clock edge k raises `rd_col_vld_o` (or `wr_col_vld_o`) for exactly one cycle, after edge k+AL. The two strobes are never high together.
- R5: A read sampled at edge k raises `rd_data_start_o` for one cycle, after edge k+AL+CL, for every AL from 0 to 4 and every CL from 3 to 5.
- R6: A write sampled at edge k raises `wr_data_start_o` for one cycle, after edge k+AL+CL-1.
- R7: Column commands on consecutive cycles are all kept, and each produces its own strobe and data-start marker in arrival order. Each marker sits at its own latency from the command that caused it.
- R8: A column command sampled e cycles after the most recent activate raises `trcd_viol_o` together with its column strobe when e+AL is less than TRCD (default 4). Otherwise the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code (see R2) |
| addr_i | input | ADDR_W (14) | Address field; bits 5:3 carry the AL code |
| cl_i | input | CL_W (3) | CAS latency, 3 to MAX_CL |
| rd_col_vld_o | output | 1 | Internal read column strobe |
| wr_col_vld_o | output | 1 | Internal write column strobe |
| rd_data_start_o | output | 1 | First read data cycle marker |
| wr_data_start_o | output | 1 | First write data cycle marker |
| trcd_viol_o | output | 1 | Column command released too early after activate |

## Verification
The assertions assume that `cl_i` stays between 3 and the maximum CAS latency. They also assume that neither `cl_i` nor the programmed AL changes while a column command is still in flight, because the release taps are computed from the current settings. The stimulus changes CL and AL only when the pipeline is idle: every observation window runs past the longest latency before the next setting is applied. It issues at most one command per cycle, so a read and a write never enter together.

// File: rtl/pcas_pkg.sv
package pcas_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRIT  = 3'd3,
    CMD_EMODE = 3'd4
  } cmd_e;

  localparam int AL_FIELD_LSB = 3;
  localparam int AL_FIELD_W   = 3;
endpackage

// File: rtl/pcas_al_reg.sv
module pcas_al_reg
  import pcas_pkg::*;
#(
  parameter int MAX_AL = 4,
  parameter int ADDR_W = 14,
  parameter int AL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AL_W-1:0]   al_o
);
  logic [AL_FIELD_W-1:0] code;
  logic                  code_legal;
  logic                  al_en;
  logic [AL_W-1:0]       al_d, al_q;

  always_comb begin
    code       = addr_i[AL_FIELD_LSB +: AL_FIELD_W];
    code_legal = (code <= AL_FIELD_W'(MAX_AL));
    al_en      = load_i && code_legal;
    al_d       = al_en ? AL_W'(code) : al_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) al_q <= '0;
    else        al_q <= al_d;
  end

  assign al_o = al_q;

  // R2: the stored latency never leaves the legal range
  p_al_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    al_q <= AL_W'(MAX_AL));

  // R3: a reserved code leaves the setting untouched
  p_reserved_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (code > AL_FIELD_W'(MAX_AL))) |=> $stable(al_q));
endmodule

// File: rtl/pcas_trcd_mon.sv
module pcas_trcd_mon #(
  parameter int TRCD = 4,
  parameter int AL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic            col_i,
  input  logic [AL_W-1:0] al_i,
  output logic            early_o
);
  localparam int CNT_W = $clog2(TRCD + 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = act_i || (cnt_q != CNT_W'(TRCD));
    if (act_i)       cnt_d = CNT_W'(1);
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
    early_o = col_i && ((int'(cnt_q) + int'(al_i)) < TRCD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(TRCD);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: the distance counter restarts on every activate
  p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/pcas_delay_line.sv
module pcas_delay_line #(
  parameter int DEPTH = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_rd_i,
  input  logic             push_wr_i,
  input  logic             push_early_i,
  input  logic [IDX_W-1:0] col_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             rd_col_o,
  output logic             wr_col_o,
  output logic             early_o,
  output logic             rd_start_o,
  output logic             wr_start_o
);
  localparam int LANES  = 3;
  localparam int L_RD   = 0;
  localparam int L_WR   = 1;
  localparam int L_EARL = 2;

  logic [LANES-1:0] push;
  assign push = {push_early_i, push_wr_i, push_rd_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DEPTH-1:0] d, q;
    always_comb d = {q[DEPTH-2:0], push[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign rd_col_o   = g_lane[L_RD].q[col_idx_i];
  assign wr_col_o   = g_lane[L_WR].q[col_idx_i];
  assign early_o    = g_lane[L_EARL].q[col_idx_i];
  assign rd_start_o = g_lane[L_RD].q[rd_idx_i];
  assign wr_start_o = g_lane[L_WR].q[wr_idx_i];

  // R7: one command per cycle enters, so lanes never collide at the head
  p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_rd_i && push_wr_i));
endmodule

// File: rtl/pcas_sched.sv
module pcas_sched
  import pcas_pkg::*;
#(
  parameter int MAX_AL = 4,
  parameter int MIN_CL = 3,
  parameter int MAX_CL = 5,
  parameter int TRCD   = 4,
  parameter int ADDR_W = 14,
  parameter int CL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CL_W-1:0]   cl_i,
  output logic              rd_col_vld_o,
  output logic              wr_col_vld_o,
  output logic              rd_data_start_o,
  output logic              wr_data_start_o,
  output logic              trcd_viol_o
);
  localparam int AL_W  = $clog2(MAX_AL + 1);
  localparam int DEPTH = MAX_AL + MAX_CL + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic             is_act, is_rd, is_wr, is_emode, is_col;
  logic [AL_W-1:0]  al;
  logic             early;
  logic [IDX_W-1:0] col_idx, rd_idx, wr_idx;

  always_comb begin
    is_act   = (cmd_i == CMD_ACT);
    is_rd    = (cmd_i == CMD_READ);
    is_wr    = (cmd_i == CMD_WRIT);
    is_emode = (cmd_i == CMD_EMODE);
    is_col   = is_rd || is_wr;
    col_idx  = IDX_W'(al);
    rd_idx   = IDX_W'(al) + IDX_W'(cl_i);
    wr_idx   = rd_idx - IDX_W'(1);
  end

  pcas_al_reg #(.MAX_AL(MAX_AL), .ADDR_W(ADDR_W), .AL_W(AL_W)) u_al (
    .clk(clk), .rst_n(rst_n), .load_i(is_emode), .addr_i(addr_i), .al_o(al)
  );

  pcas_trcd_mon #(.TRCD(TRCD), .AL_W(AL_W)) u_trcd (
    .clk(clk), .rst_n(rst_n), .act_i(is_act), .col_i(is_col),
    .al_i(al), .early_o(early)
  );

  pcas_delay_line #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .push_rd_i(is_rd), .push_wr_i(is_wr), .push_early_i(early),
    .col_idx_i(col_idx), .rd_idx_i(rd_idx), .wr_idx_i(wr_idx),
    .rd_col_o(rd_col_vld_o), .wr_col_o(wr_col_vld_o), .early_o(trcd_viol_o),
    .rd_start_o(rd_data_start_o), .wr_start_o(wr_data_start_o)
  );

  // R5: CAS latency input assumed to stay in its legal window
  p_cl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_i >= CL_W'(MIN_CL)) && (cl_i <= CL_W'(MAX_CL)));

  // R4: read and write column strobes are mutually exclusive
  p_col_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_col_vld_o && wr_col_vld_o));

  // R8: a violation flag only accompanies a column strobe
  p_viol_with_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trcd_viol_o |-> (rd_col_vld_o || wr_col_vld_o));
endmodule

// File: tb/tb_pcas_sched.sv
module tb_pcas_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TRCD       = 4;
  localparam logic [2:0] C_IDLE = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_EM = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd;
  logic [13:0] addr;
  logic [2:0]  cl;
  logic rd_col, wr_col, rd_st, wr_st, viol;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rd_log [8];
  int wr_log [8];
  int n_rd = 0, n_wr = 0;
  bit logging = 1'b0;

  // observation results of one run
  int f_rdc, f_wrc, f_rds, f_wrs, f_vio;
  int c_rdc, c_wrc, c_rds, c_wrs, c_vio;

  pcas_sched dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .cl_i(cl),
    .rd_col_vld_o(rd_col), .wr_col_vld_o(wr_col),
    .rd_data_start_o(rd_st), .wr_data_start_o(wr_st), .trcd_viol_o(viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (logging) begin
      if (rd_st && n_rd < 8) begin rd_log[n_rd] = cyc; n_rd++; end
      if (wr_st && n_wr < 8) begin wr_log[n_wr] = cyc; n_wr++; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input logic [13:0] a);
    @(negedge clk);
    cmd  = c;
    addr = a;
    @(posedge clk);
    #1;
    cmd  = C_IDLE;
    addr = '0;
  endtask

  task automatic prog_al(input int v);
    send(C_EM, 14'(v << 3));
    send(C_IDLE, '0);
  endtask

  // activate, wait so that the column command lands gap cycles later, observe
  task automatic run_col(input logic [2:0] c, input int gap);
    send(C_ACT, '0);
    for (int i = 1; i < gap; i++) send(C_IDLE, '0);
    send(c, '0);
    f_rdc = -1; f_wrc = -1; f_rds = -1; f_wrs = -1; f_vio = -1;
    c_rdc = 0;  c_wrc = 0;  c_rds = 0;  c_wrs = 0;  c_vio = 0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      if (rd_col) begin c_rdc++; if (f_rdc < 0) f_rdc = m; end
      if (wr_col) begin c_wrc++; if (f_wrc < 0) f_wrc = m; end
      if (rd_st)  begin c_rds++; if (f_rds < 0) f_rds = m; end
      if (wr_st)  begin c_wrs++; if (f_wrs < 0) f_wrs = m; end
      if (viol)   begin c_vio++; if (f_vio < 0) f_vio = m; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k, exp_rd, exp_wr;
    rst_n = 1'b0;
    cmd   = C_IDLE;
    addr  = '0;
    cl    = 3'd3;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check({rd_col, wr_col, rd_st, wr_st, viol} == 5'b0, "R1", "outputs in reset",
          int'({rd_col, wr_col, rd_st, wr_st, viol}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rd_col, wr_col, rd_st, wr_st, viol} == 5'b0, "R1", "outputs after reset",
          int'({rd_col, wr_col, rd_st, wr_st, viol}), 0);

    // R1: AL defaults to 0, so read data starts after CL
    run_col(C_RD, TRCD);
    check(f_rds == 3, "R1", "default AL read start", f_rds, 3);

    // R2 R4 R5 R6 R8: full sweep of AL 0..4 and CL 3..5
    for (int a = 0; a <= 4; a++) begin
      for (int c = 3; c <= 5; c++) begin
        cl = 3'(c);
        prog_al(a);
        run_col(C_RD, TRCD);
        check(f_rdc == a && c_rdc == 1, "R4", "read strobe position", f_rdc, a);
        check(c_wrc == 0 && c_wrs == 0, "R4", "no write activity on read", c_wrc + c_wrs, 0);
        check(f_rds == a + c && c_rds == 1, "R5", "read data start", f_rds, a + c);
        check(c_vio == 0, "R8", "no flag when gap meets TRCD", c_vio, 0);
        run_col(C_WR, TRCD);
        check(f_wrc == a && c_wrc == 1, "R4", "write strobe position", f_wrc, a);
        check(f_wrs == a + c - 1 && c_wrs == 1, "R6", "write data start", f_wrs, a + c - 1);
        check(c_rdc == 0 && c_rds == 0, "R2", "no read activity on write", c_rdc + c_rds, 0);
      end
    end

    // R3: reserved codes keep the old AL
    cl = 3'd3;
    prog_al(2);
    for (int r = 5; r <= 7; r++) begin
      prog_al(r);
      run_col(C_RD, TRCD);
      check(f_rds == 5, "R3", "reserved AL code ignored", f_rds, 5);
    end

    // R8: early column commands for several AL values
    for (int a = 0; a <= 4; a++) begin
      for (int g = 1; g <= 2; g++) begin
        prog_al(a);
        run_col(C_RD, g);
        if (g + a < TRCD) begin
          check(f_vio == a && c_vio == 1, "R8", "violation flag with strobe", f_vio, a);
        end else begin
          check(c_vio == 0, "R8", "no violation when AL covers gap", c_vio, 0);
        end
        check(f_rds == a + 3, "R8", "early read still released", f_rds, a + 3);
      end
    end

    // R7: back-to-back read, read, write with AL=2 CL=4
    cl = 3'd4;
    prog_al(2);
    n_rd = 0; n_wr = 0; logging = 1'b1;
    send(C_RD, '0);
    k = cyc;
    send(C_RD, '0);
    send(C_WR, '0);
    for (int i = 0; i < 16; i++) send(C_IDLE, '0);
    logging = 1'b0;
    exp_rd = k + 6;
    exp_wr = k + 2 + 5;
    check(n_rd == 2, "R7", "read marker count", n_rd, 2);
    check(n_wr == 1, "R7", "write marker count", n_wr, 1);
    check(rd_log[0] == exp_rd, "R7", "first read marker cycle", rd_log[0], exp_rd);
    check(rd_log[1] == exp_rd + 1, "R7", "second read marker cycle", rd_log[1], exp_rd + 1);
    check(wr_log[0] == exp_wr, "R7", "write marker cycle", wr_log[0], exp_wr);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule